// File: doc/BRIEF.md
# Serial Shift Engine with Programmable Select Sequencer

The engine is a serial master that moves an arbitrary number of bits, from zero up to a parameter limit, on a data-out line while capturing a data-in line on the same clock cycles. It serves as a plain SPI master, and it can also drive a JTAG port. In that case data-out carries TDI, data-in carries TDO, the serial clock is TCK and the select line is TMS. The host loads a bit count, a transmit word, a select pattern with its length, a clock divider and a few mode bits, then pulses `start`. It waits for the one-cycle `done` pulse and reads the right-aligned receive word.

The select line does not simply release after the data. A pattern of up to seven levels is played on it, one level per serial clock cycle. The pattern starts on the cycle that carries the final data bit. A single transfer can therefore leave a shift state with TMS high on the last data edge and then walk the TAP onward at the same clock rate. A pattern of a low level followed by highs gives the usual SPI release delay. If the bit count is zero and the pattern length is not, only pattern cycles are issued. An optional loop mode sends each captured input bit back out on the next cycle.

The controller has three named states. **IDLE** waits for `start`. A start with no cycles to issue stays in IDLE and pulses `done`; any other start moves to **LOW**. **LOW** holds TCK low for one half period and then moves to **HIGH** on the rising edge, where the input bit is captured. **HIGH** holds TCK high for one half period and then takes the falling edge. From there it goes back to **LOW** with the next cycle's outputs driven, or to **IDLE** after the last cycle.

Top module: `jtsh_engine`

## Requirements
- R1: A transfer with bit count N and pattern length L (L is the 3-bit field, 0 to 7) issues exactly N-1+max(L,1) TCK pulses when N>0, and exactly L pulses when N=0, with no padding to a byte boundary.
- R2: After a transfer, `rx_word` bit k holds the data-in level captured at the rising TCK edge of data cycle k, for k<N. Bit 0 is the first bit received and all bits at N or above read 0. The word does not change while the engine is idle.
- R3: TCK idles low whenever the engine is not busy. Each half period lasts `clk_div`+1 system clock cycles, so successive rising edges are 2*(`clk_div`+1) cycles apart.
- R4: In data cycle k (k<N), with loop mode off, `tdi` carries `tx_word` bit k. `tdi` and `tms` change only while TCK is low, and data-in is sampled on the rising TCK edge.
- R5: The pattern starts on cycle N-1, or on cycle 0 when N=0. At cycle N-1+j, `tms` equals `sel_pattern` bit j. Earlier cycles drive `tms` low, and with L=0 every cycle drives `tms` low.
- R6: `tms` resets high. After a transfer it keeps the level of that transfer's last cycle until the next transfer begins.
- R7: In cycles after the data phase, `tdi` keeps its previous level when `fill_hold`=1 and drives `fill_level` when `fill_hold`=0.
- R8: With `loop_en`=1, data cycle 0 carries `tx_word` bit 0, and data cycle k>0 carries the data-in bit captured in cycle k-1.
- R9: `done` is a single-cycle pulse. It rises after the falling edge of the last TCK cycle, and at that point `busy` is low and TCK is low.
- R10: A start with N=0 and L=0 produces a `done` pulse with no TCK pulse and leaves `tms` unchanged.
- R11: A `start` pulse while `busy` is high is ignored: the running transfer keeps its cycle count and its outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a transfer with the present configuration |
| bit_count | input | CNT_W | Number of data bits N |
| tx_word | input | DATA_W | Transmit bits, bit 0 sent first |
| sel_pattern | input | PAT_W | Select-line levels per cycle, bit 0 first |
| sel_len | input | LEN_W | Number of pattern cycles L |
| fill_hold | input | 1 | After data: 1 holds `tdi`, 0 drives `fill_level` |
| fill_level | input | 1 | Fixed `tdi` level after data |
| loop_en | input | 1 | Send each captured bit out one cycle later |
| clk_div | input | DIV_W | Half period minus one, in system cycles |
| tdo | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | DATA_W | Captured bits, right-aligned |
| tck | output | 1 | Serial clock |
| tdi | output | 1 | Serial data out |
| tms | output | 1 | Select / mode line |

## Verification
The hardest case to reach from the ports is the overlap where the pattern begins on the last data bit. Here `tms`, `tdi` and the captured input all matter on the same edge, and the fill rule then decides `tdi` for cycles that hold no data. The bench records `tms` and `tdi` at every rising TCK edge and drives `tdo` from a random per-cycle sequence. It covers a one-bit transfer with a one-cycle pattern, a pure state walk with zero data bits, a full-width shift with no pattern, and random mixes of length, pattern, fill and loop settings at several dividers.

// File: rtl/jtsh_pkg.sv
package jtsh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } jtsh_state_e;
endpackage

// File: rtl/jtsh_tck_gen.sv
// Half-period timer: one pulse every (div+1) system cycles while running.
module jtsh_tck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             phase_end
);
    logic [DIV_W-1:0] cnt_q;

    assign phase_end = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || phase_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: the half-period counter never passes its limit
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= div));
endmodule

// File: rtl/jtsh_sel_seq.sv
// Select-line level for a given cycle index of a transfer.
module jtsh_sel_seq #(
    parameter int CNT_W = 6,
    parameter int CYC_W = 6,
    parameter int LEN_W = 3,
    parameter int PAT_W = 8
) (
    input  logic [CYC_W-1:0] cyc,
    input  logic [CNT_W-1:0] n_bits,
    input  logic [LEN_W-1:0] len,
    input  logic [PAT_W-1:0] pattern,
    output logic             tms_bit,
    output logic             data_cyc
);
    logic [CYC_W-1:0] first_pat;
    logic [CYC_W-1:0] offset;

    always_comb begin
        first_pat = (n_bits == '0) ? '0 : (CYC_W'(n_bits) - CYC_W'(1));
        offset    = cyc - first_pat;
        data_cyc  = (cyc < CYC_W'(n_bits));
        tms_bit   = 1'b0;
        if ((len != '0) && (cyc >= first_pat)) begin
            for (int i = 0; i < PAT_W; i++) begin
                if (offset == CYC_W'(i)) tms_bit = pattern[i];
            end
        end
    end
endmodule

// File: rtl/jtsh_engine.sv
module jtsh_engine #(
    parameter  int DATA_W = 32,
    parameter  int LEN_W  = 3,
    parameter  int DIV_W  = 8,
    localparam int CNT_W  = $clog2(DATA_W + 1),
    localparam int PAT_W  = 1 << LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  bit_count,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [PAT_W-1:0]  sel_pattern,
    input  logic [LEN_W-1:0]  sel_len,
    input  logic              fill_hold,
    input  logic              fill_level,
    input  logic              loop_en,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              tdo,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word,
    output logic              tck,
    output logic              tdi,
    output logic              tms
);
    import jtsh_pkg::*;

    localparam int CYC_W = $clog2(DATA_W + PAT_W + 1);

    jtsh_state_e       state_q, state_d;
    logic [CYC_W-1:0]  cyc_q, last_q;
    logic [CNT_W-1:0]  n_q;
    logic [LEN_W-1:0]  len_q;
    logic [PAT_W-1:0]  pat_q;
    logic [DATA_W-1:0] tx_q, rx_q;
    logic [DIV_W-1:0]  div_q;
    logic              loop_q, hold_q, lvl_q, tdo_q;
    logic              tck_q, tdi_q, tms_q, done_q;

    // Values for the cycle about to be driven
    logic [CYC_W-1:0]  nxt_cyc, total_in, ext_len;
    logic [CNT_W-1:0]  sel_n;
    logic [LEN_W-1:0]  sel_l;
    logic [PAT_W-1:0]  sel_p;
    logic [DATA_W-1:0] sel_tx, tx_shift;
    logic              sel_loop, sel_hold, sel_lvl;
    logic              nxt_tms, nxt_data, nxt_tdi, cur_data, zero_xfer;
    logic              phase_end;

    jtsh_tck_gen #(.DIV_W(DIV_W)) u_tck (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state_q != ST_IDLE),
        .div       (div_q),
        .phase_end (phase_end)
    );

    jtsh_sel_seq #(.CNT_W(CNT_W), .CYC_W(CYC_W), .LEN_W(LEN_W), .PAT_W(PAT_W)) u_seq (
        .cyc      (nxt_cyc),
        .n_bits   (sel_n),
        .len      (sel_l),
        .pattern  (sel_p),
        .tms_bit  (nxt_tms),
        .data_cyc (nxt_data)
    );

    always_comb begin
        if (state_q == ST_IDLE) begin
            nxt_cyc  = '0;
            sel_n    = bit_count;
            sel_l    = sel_len;
            sel_p    = sel_pattern;
            sel_tx   = tx_word;
            sel_loop = loop_en;
            sel_hold = fill_hold;
            sel_lvl  = fill_level;
        end else begin
            nxt_cyc  = cyc_q + CYC_W'(1);
            sel_n    = n_q;
            sel_l    = len_q;
            sel_p    = pat_q;
            sel_tx   = tx_q;
            sel_loop = loop_q;
            sel_hold = hold_q;
            sel_lvl  = lvl_q;
        end
        tx_shift = sel_tx >> nxt_cyc;
        if (nxt_data) begin
            nxt_tdi = (sel_loop && (nxt_cyc != '0)) ? tdo_q : tx_shift[0];
        end else begin
            nxt_tdi = sel_hold ? tdi_q : sel_lvl;
        end
        ext_len   = (sel_len == '0) ? CYC_W'(1) : CYC_W'(sel_len);
        total_in  = (bit_count == '0) ? CYC_W'(sel_len)
                                      : (CYC_W'(bit_count) + ext_len - CYC_W'(1));
        zero_xfer = (total_in == '0);
        cur_data  = (cyc_q < CYC_W'(n_q));
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start && !zero_xfer) state_d = ST_LOW;
            ST_LOW:  if (phase_end) state_d = ST_HIGH;
            ST_HIGH: if (phase_end) state_d = (cyc_q == last_q) ? ST_IDLE : ST_LOW;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            last_q <= '0;
            n_q    <= '0;
            len_q  <= '0;
            pat_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            div_q  <= '0;
            loop_q <= 1'b0;
            hold_q <= 1'b0;
            lvl_q  <= 1'b0;
            tdo_q  <= 1'b0;
            tck_q  <= 1'b0;
            tdi_q  <= 1'b0;
            tms_q  <= 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        n_q    <= bit_count;
                        len_q  <= sel_len;
                        pat_q  <= sel_pattern;
                        tx_q   <= tx_word;
                        loop_q <= loop_en;
                        hold_q <= fill_hold;
                        lvl_q  <= fill_level;
                        div_q  <= clk_div;
                        last_q <= total_in - CYC_W'(1);
                        cyc_q  <= '0;
                        rx_q   <= '0;
                        if (zero_xfer) begin
                            done_q <= 1'b1;
                        end else begin
                            tdi_q <= nxt_tdi;
                            tms_q <= nxt_tms;
                        end
                    end
                end
                ST_LOW: begin
                    if (phase_end) begin
                        tck_q <= 1'b1;
                        tdo_q <= tdo;
                        for (int i = 0; i < DATA_W; i++) begin
                            if (cur_data && (cyc_q == CYC_W'(i))) rx_q[i] <= tdo;
                        end
                    end
                end
                ST_HIGH: begin
                    if (phase_end) begin
                        tck_q <= 1'b0;
                        if (cyc_q == last_q) begin
                            done_q <= 1'b1;
                        end else begin
                            cyc_q <= nxt_cyc;
                            tdi_q <= nxt_tdi;
                            tms_q <= nxt_tms;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign rx_word = rx_q;
    assign tck     = tck_q;
    assign tdi     = tdi_q;
    assign tms     = tms_q;

    a_r3_tck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck_q);
    a_r4_tms_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        (tms_q != $past(tms_q)) |-> !tck_q);
    a_r4_tdi_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        (tdi_q != $past(tdi_q)) |-> !tck_q);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy && !tck_q));
    a_r2_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && !$past(start)) |-> $stable(rx_q));
    a_r1_cyc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cyc_q <= last_q));
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(n_q) && $stable(last_q)));
endmodule

// File: tb/jtsh_engine_tb.sv
module jtsh_engine_tb_top;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 3;
    localparam int DIV_W  = 8;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int PAT_W  = 1 << LEN_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CNT_W-1:0]  bit_count = '0;
    logic [DATA_W-1:0] tx_word = '0;
    logic [PAT_W-1:0]  sel_pattern = '0;
    logic [LEN_W-1:0]  sel_len = '0;
    logic fill_hold = 1'b0, fill_level = 1'b0, loop_en = 1'b0;
    logic [DIV_W-1:0]  clk_div = '0;
    logic tdo;
    logic busy, done, tck, tdi, tms;
    logic [DATA_W-1:0] rx_word;

    always #5 clk = ~clk;

    jtsh_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_count(bit_count),
        .tx_word(tx_word), .sel_pattern(sel_pattern), .sel_len(sel_len),
        .fill_hold(fill_hold), .fill_level(fill_level), .loop_en(loop_en),
        .clk_div(clk_div), .tdo(tdo), .busy(busy), .done(done),
        .rx_word(rx_word), .tck(tck), .tdi(tdi), .tms(tms)
    );

    int n_chk = 0;
    int n_fail = 0;

    // tdo source and edge monitor
    logic [63:0] tdo_seq = '0;
    int  rise_cnt = 0;
    logic tck_prev = 1'b0;
    logic tms_log [0:63];
    logic tdi_log [0:63];
    int  sys_cyc = 0;
    int  last_rise = -1;
    int  cur_div = 0;

    assign tdo = tdo_seq[rise_cnt[5:0]];

    always @(negedge clk) begin
        sys_cyc = sys_cyc + 1;
        if (tck && !tck_prev) begin
            if (rise_cnt < 64) begin
                tms_log[rise_cnt] = tms;
                tdi_log[rise_cnt] = tdi;
            end
            if (last_rise >= 0) begin
                n_chk = n_chk + 1;
                if (sys_cyc - last_rise != 2 * (cur_div + 1)) begin
                    n_fail = n_fail + 1;
                    $display("FAIL R3 rise spacing: actual %0d expected %0d",
                             sys_cyc - last_rise, 2 * (cur_div + 1));
                end
            end
            last_rise = sys_cyc;
            rise_cnt  = rise_cnt + 1;
        end
        tck_prev = tck;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int f_total(input int n, input int l);
        if (n == 0) return l;
        return n - 1 + ((l == 0) ? 1 : l);
    endfunction

    function automatic bit f_tms(input int k, input int n, input int l, input logic [PAT_W-1:0] p);
        int ps;
        ps = (n == 0) ? 0 : n - 1;
        if (l == 0 || k < ps) return 1'b0;
        return p[k - ps];
    endfunction

    task automatic run_xfer(input int n, input int l, input logic [PAT_W-1:0] p,
                            input logic [DATA_W-1:0] tx, input bit hold, input bit lvl,
                            input bit lp, input int div, input bit poke);
        int  total, waited;
        bit  prev_tdi, prev_tms, e_tdi, got_done;
        logic [DATA_W-1:0] e_rx;
        @(negedge clk);
        tdo_seq   = {$urandom, $urandom};
        rise_cnt  = 0;
        last_rise = -1;
        cur_div   = div;
        prev_tdi  = tdi;
        prev_tms  = tms;
        bit_count = CNT_W'(n);
        sel_len   = LEN_W'(l);
        sel_pattern = p;
        tx_word   = tx;
        fill_hold = hold;
        fill_level = lvl;
        loop_en   = lp;
        clk_div   = DIV_W'(div);
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
        total     = f_total(n, l);
        got_done  = done;
        waited    = 0;
        while (!got_done && waited < 5000) begin
            @(negedge clk);
            waited = waited + 1;
            if (poke && waited == 3) begin
                bit_count = CNT_W'((n + 5) % (DATA_W + 1));
                sel_len   = LEN_W'((l + 3) % 8);
                start     = 1'b1;
            end else begin
                start = 1'b0;
            end
            got_done = done;
        end
        start = 1'b0;
        check(got_done, "R9 done seen (watchdog)", int'(got_done), 1);
        check(rise_cnt == total, poke ? "R11 count with start while busy" : "R1 tck pulse count",
              rise_cnt, total);
        check(!busy && !tck, "R9 idle at done", int'({busy, tck}), 0);
        e_rx = '0;
        for (int k = 0; k < n; k++) e_rx[k] = tdo_seq[k];
        check(rx_word == e_rx, "R2 rx word", int'(rx_word), int'(e_rx));
        e_tdi = prev_tdi;
        for (int k = 0; k < total && k < rise_cnt; k++) begin
            bit et;
            et = f_tms(k, n, l, p);
            check(tms_log[k] == et, "R5 tms per cycle", int'(tms_log[k]), int'(et));
            if (k < n) e_tdi = lp ? ((k == 0) ? tx[0] : tdo_seq[k-1]) : tx[k];
            else       e_tdi = hold ? e_tdi : lvl;
            check(tdi_log[k] == e_tdi,
                  (k >= n) ? "R7 fill tdi" : (lp ? "R8 loop tdi" : "R4 data tdi"),
                  int'(tdi_log[k]), int'(e_tdi));
        end
        if (total > 0) begin
            bit et;
            et = f_tms(total - 1, n, l, p);
            check(tms == et, "R6 tms after transfer", int'(tms), int'(et));
        end else begin
            check(tms == prev_tms, "R10 tms unchanged", int'(tms), int'(prev_tms));
        end
        @(negedge clk);
        check(!done, "R9 done single pulse", int'(done), 0);
    endtask

    initial begin
        #2_000_000;
        n_chk = n_chk + 1;
        n_fail = n_fail + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check(tms == 1'b1 && tck == 1'b0, "R6 reset tms high, R3 tck low", int'({tms, tck}), 2);
        check(!busy && !done && rx_word == '0, "R9 reset idle", int'({busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed corners
        run_xfer(1, 1, 8'b1, 32'h1, 1, 0, 0, 0, 0);               // single bit, exit on last
        run_xfer(0, 5, 8'b00110, 32'h0, 1, 0, 0, 1, 0);           // pure state walk
        run_xfer(32, 0, 8'h0, 32'hA5C3_0F96, 0, 1, 0, 1, 0);      // full width, tms stays low
        run_xfer(7, 4, 8'b1110, 32'h55, 0, 1, 0, 2, 0);           // SPI-style release, partial byte
        run_xfer(9, 3, 8'b011, 32'h1F3, 0, 0, 1, 0, 0);           // loop mode
        run_xfer(5, 6, 8'b101101, 32'h13, 1, 0, 0, 3, 0);         // hold fill
        run_xfer(0, 0, 8'hFF, 32'hFFFF, 0, 1, 0, 0, 0);           // R10 nothing to do
        run_xfer(12, 2, 8'b11, 32'hABC, 0, 0, 0, 2, 1);           // R11 start while busy
        for (int t = 0; t < 40; t++) begin
            run_xfer($urandom_range(0, DATA_W), $urandom_range(0, 7), PAT_W'($urandom),
                     $urandom, 1'($urandom), 1'($urandom), 1'($urandom),
                     $urandom_range(0, 3), 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule